// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-facing register file of a simple serial port. A synchronous bus port with word addresses and 32-bit data reaches control words, a transmit data word, two status/data words over a 16-byte receive FIFO, and a set of interrupt words (raw, mask, masked and acknowledge). On the line side it takes received bytes through a valid/data input and emits transmitted bytes as a one-clock valid/data strobe. Bit-level serialisation, baud timing, DMA and parity are handled elsewhere.

Software drains received bytes through the status/data word. One address returns the oldest byte and removes it from the FIFO. A second address returns the same word and leaves the FIFO as it is. A single level interrupt output is high while any raw interrupt bit that is enabled in the mask is set. Transmit-done bits are cleared by writing ones to the acknowledge word. The first acknowledge after a transmit write does not clear bit 0, so one transmit-done indication stays set.

Top module: `sio_regfile`

## Requirements
- R1: After reset the receive control word (byte offset 0x08) reads 0x0001_0000, all other words read 0, the FIFO is empty and `irq` is low.
- R2: A byte on `rx_data` with `rx_valid` high enters the FIFO only while bit 3 of the receive control word is 1. Otherwise it is dropped.
- R3: A read of either status/data word (0x20, 0x24) returns the oldest FIFO byte in bits 7:0. Bit 16 is 1 when the FIFO holds data, and bits 22 and 24 always read 1. Any read result appears on `bus_rdata` in the cycle after the request.
- R4: The FIFO holds 16 bytes. A byte that arrives while the FIFO already holds 16 is discarded, and the stored bytes are unchanged.
- R5: A read at 0x20 removes the oldest byte when the FIFO is not empty. A read at 0x24 never changes the FIFO.
- R6: A pop read and an accepted incoming byte in the same cycle both take effect, and the fill count is unchanged. The full check uses the count before that cycle.
- R7: A write to the transmit data word (0x1C) does the following:
  - it drives `tx_valid` high for exactly one clock in the next cycle, with `tx_data` equal to the written bits 7:0;
  - it sets raw interrupt bits 0 and 1;
  - it sets a pending-transmit flag;
  - the written word reads back from 0x1C.
- R8: A write to the acknowledge word (0x30) clears each raw bit written as 1. If the pending-transmit flag is set, bit 0 of the written value is treated as 0 and the flag is cleared. The acknowledge word reads back the value after that adjustment.
- R9: Raw interrupt bit 3 (0x34) equals "FIFO not empty" at all times. Writes to the raw word (0x34) and the masked word (0x38) are ignored.
- R10: The masked word (0x38) reads raw AND mask (mask at 0x2C). `irq` is high exactly when the masked value is non-zero.
- R11: Other word offsets below 0x3C store writes and read them back. Offsets 0x3C and above read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Word address (byte offset / 4) |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after a read request |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | One-clock transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt, any masked bit set |

## Verification
Each bus access and each received byte is registered on the rising edge where it is presented. Read data, the transmit strobe, FIFO changes, raw bits and `irq` are therefore all due one cycle after the stimulus, with no further latency. The bench drives stimulus on the falling edge and samples every result on the next falling edge, which lies half a cycle after the edge that registers it. For the strobe, the bench also checks the falling edge after that to confirm the one-clock width. Pop/peek ordering, overflow, the same-cycle pop and push, and the acknowledge quirk are each checked through later bus reads.

// File: rtl/sio_pkg.sv
package sio_pkg;
    // word indices (byte offset / 4); software depends on these
    localparam int unsigned WORD_TXCTRL  = 0;
    localparam int unsigned WORD_TXDMA   = 1;
    localparam int unsigned WORD_RXCTRL  = 2;
    localparam int unsigned WORD_DOUT    = 7;
    localparam int unsigned WORD_POP     = 8;
    localparam int unsigned WORD_PEEK    = 9;
    localparam int unsigned WORD_MASK    = 11;
    localparam int unsigned WORD_ACK     = 12;
    localparam int unsigned WORD_RAW     = 13;
    localparam int unsigned WORD_MASKED  = 14;
    localparam int unsigned NUM_WORDS    = 15;

    // bit positions
    localparam int unsigned RX_EN_BIT    = 3;
    localparam int unsigned AVAIL_BIT    = 16;
    localparam int unsigned TX_IDLE_BIT  = 22;
    localparam int unsigned TX_RDY_BIT   = 24;
    localparam int unsigned IRQ_TX_A     = 0;
    localparam int unsigned IRQ_TX_B     = 1;
    localparam int unsigned IRQ_RX       = 3;

    localparam logic [31:0] RXCTRL_RESET = 32'h0001_0000;
endpackage

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [DW-1:0]    din_i,
    input  logic             pop_i,
    output logic [DW-1:0]    head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             empty_o
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        push_ok = push_i && (st_q.count != CNT_W'(DEPTH));
        pop_ok  = pop_i && (st_q.count != '0);
        st_d    = st_q;
        if (push_ok) st_d.wr_ptr = bump(st_q.wr_ptr);
        if (pop_ok)  st_d.rd_ptr = bump(st_q.rd_ptr);
        case ({push_ok, pop_ok})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr_ptr] <= din_i;
    end

    assign head_o  = mem_q[st_q.rd_ptr];
    assign count_o = st_q.count;
    assign empty_o = (st_q.count == '0);

    // R4: fill never exceeds capacity
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));
    // R4: a byte arriving at full is dropped
    assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == CNT_W'(DEPTH) && !pop_i) |=> st_q.count == CNT_W'(DEPTH));
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_wr_i,
    input  logic          ack_wr_i,
    input  logic [DW-1:0] ack_val_i,
    input  logic          rx_avail_i,
    input  logic [DW-1:0] mask_i,
    output logic [DW-1:0] ack_store_o,
    output logic [DW-1:0] raw_o,
    output logic [DW-1:0] masked_o,
    output logic          irq_o
);
    import sio_pkg::*;

    typedef struct packed {
        logic tx_a;
        logic tx_b;
        logic pending;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [DW-1:0] ack_eff;

    always_comb begin
        ack_eff = ack_val_i;
        if (st_q.pending) ack_eff[IRQ_TX_A] = 1'b0;
    end

    always_comb begin
        st_d = st_q;
        if (tx_wr_i) begin
            st_d.tx_a    = 1'b1;
            st_d.tx_b    = 1'b1;
            st_d.pending = 1'b1;
        end else if (ack_wr_i) begin
            if (ack_eff[IRQ_TX_A]) st_d.tx_a = 1'b0;
            if (ack_eff[IRQ_TX_B]) st_d.tx_b = 1'b0;
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        raw_o           = '0;
        raw_o[IRQ_TX_A] = st_q.tx_a;
        raw_o[IRQ_TX_B] = st_q.tx_b;
        raw_o[IRQ_RX]   = rx_avail_i;
    end

    assign ack_store_o = ack_eff;
    assign masked_o    = raw_o & mask_i;
    assign irq_o       = |masked_o;

    // R7: transmit write raises both done bits and the pending flag
    assert_tx_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_i |=> (st_q.tx_a && st_q.tx_b && st_q.pending));
    // R8: while a transmit is pending, bit 0 cannot have been cleared
    assert_pending_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pending |-> st_q.tx_a);
    // R8: acknowledge always retires the pending flag
    assert_ack_clears_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr_i && !tx_wr_i) |=> !st_q.pending);
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned FIFO_DEPTH = 16,
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1),
    localparam int unsigned IDX_W     = $clog2(sio_pkg::NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    import sio_pkg::*;

    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] words;
        logic [DATA_W-1:0]                rdata;
        logic                             tx_valid;
        logic [7:0]                       tx_data;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic wr, rd, in_range, writable;
    logic hit_dout, hit_ack, hit_pop, hit_peek, hit_raw, hit_masked;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] stat_word, rd_mux, ack_store, raw_word, masked_word;
    logic [7:0] fifo_head;
    logic [CNT_W-1:0] fifo_count;
    logic fifo_empty, rx_enable, rx_push;

    // address decode
    always_comb begin
        wr         = bus_en && bus_we;
        rd         = bus_en && !bus_we;
        in_range   = bus_addr < ADDR_W'(NUM_WORDS);
        idx        = bus_addr[IDX_W-1:0];
        hit_dout   = bus_addr == ADDR_W'(WORD_DOUT);
        hit_ack    = bus_addr == ADDR_W'(WORD_ACK);
        hit_pop    = bus_addr == ADDR_W'(WORD_POP);
        hit_peek   = bus_addr == ADDR_W'(WORD_PEEK);
        hit_raw    = bus_addr == ADDR_W'(WORD_RAW);
        hit_masked = bus_addr == ADDR_W'(WORD_MASKED);
        writable   = in_range && !hit_pop && !hit_peek && !hit_raw && !hit_masked;
    end

    assign rx_enable = st_q.words[WORD_RXCTRL][RX_EN_BIT];
    assign rx_push   = rx_valid && rx_enable;

    sio_rx_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (rx_push),
        .din_i   (rx_data),
        .pop_i   (rd && hit_pop),
        .head_o  (fifo_head),
        .count_o (fifo_count),
        .empty_o (fifo_empty)
    );

    sio_irq_ctrl #(.DW(DATA_W)) irq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_wr_i     (wr && hit_dout),
        .ack_wr_i    (wr && hit_ack),
        .ack_val_i   (bus_wdata),
        .rx_avail_i  (!fifo_empty),
        .mask_i      (st_q.words[WORD_MASK]),
        .ack_store_o (ack_store),
        .raw_o       (raw_word),
        .masked_o    (masked_word),
        .irq_o       (irq)
    );

    // status/data word
    always_comb begin
        stat_word              = '0;
        stat_word[7:0]         = fifo_head;
        stat_word[AVAIL_BIT]   = !fifo_empty;
        stat_word[TX_IDLE_BIT] = 1'b1;
        stat_word[TX_RDY_BIT]  = 1'b1;
    end

    // read mux
    always_comb begin
        if (hit_pop || hit_peek)  rd_mux = stat_word;
        else if (hit_raw)         rd_mux = raw_word;
        else if (hit_masked)      rd_mux = masked_word;
        else if (in_range)        rd_mux = st_q.words[idx];
        else                      rd_mux = '0;
    end

    // next state
    always_comb begin
        st_d          = st_q;
        st_d.tx_valid = 1'b0;
        if (wr && writable)
            st_d.words[idx] = hit_ack ? ack_store : bus_wdata;
        if (wr && hit_dout) begin
            st_d.tx_valid = 1'b1;
            st_d.tx_data  = bus_wdata[7:0];
        end
        if (rd) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q                    <= '0;
            st_q.words[WORD_RXCTRL] <= RXCTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign tx_valid  = st_q.tx_valid;
    assign tx_data   = st_q.tx_data;

    // R7: strobe follows a data-out write by one cycle and only then
    assert_tx_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_dout) |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));
    assert_tx_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && hit_dout) |=> !tx_valid);
    // R5: peeking without a push leaves the fill count alone
    assert_peek_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_peek && !rx_push) |=> $stable(fifo_count));
    // R5: popping a non-empty FIFO without a push removes one byte
    assert_pop_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_pop && !rx_push && !fifo_empty) |=> fifo_count == $past(fifo_count) - 1'b1);
    // R2: with reception off and no pop the count cannot move
    assert_rx_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && !(rd && hit_pop)) |=> $stable(fifo_count));
    // R10: enabled receive interrupt drives the output
    assert_irq_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.words[WORD_MASK][IRQ_RX] && !fifo_empty) |-> irq);
endmodule

// File: tb/sio_regfile_tb.sv
module sio_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    sio_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
        .tx_data(tx_data), .irq(irq)
    );

    localparam logic [5:0] A_RXCTRL = 6'h02, A_GEN = 6'h04, A_DOUT = 6'h07,
        A_POP = 6'h08, A_PEEK = 6'h09, A_MASK = 6'h0B, A_ACK = 6'h0C,
        A_RAW = 6'h0D, A_MASKED = 6'h0E, A_HOLE = 6'h0F, A_FAR = 6'h10;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    function automatic logic [31:0] stat(input logic [7:0] b);
        return 32'h0141_0000 | {24'h0, b};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(A_RXCTRL, v); check("R1 rxctrl", v, 32'h0001_0000);
        rd(A_RAW, v);    check("R1 raw", v, 32'h0);
        rd(A_MASK, v);   check("R1 mask", v, 32'h0);
        rd(A_PEEK, v);   check("R1 R3 empty stat", v & 32'hFFFF_0000, 32'h0140_0000);
    endtask

    task automatic t_rx_gate();
        logic [31:0] v;
        push(8'h99);
        rd(A_PEEK, v); check("R2 disabled drop", v & 32'hFFFF_0000, 32'h0140_0000);
        wr(A_RXCTRL, 32'h0001_0008);
        push(8'h3C);
        rd(A_PEEK, v); check("R2 enabled accept", v, stat(8'h3C));
        rd(A_POP, v);  check("R2 pop", v, stat(8'h3C));
    endtask

    task automatic t_peek_pop();
        logic [31:0] v;
        push(8'hA1); push(8'hB2); push(8'hC3);
        rd(A_RAW, v);  check("R9 raw rx bit", v, 32'h8);
        rd(A_PEEK, v); check("R3 peek", v, stat(8'hA1));
        rd(A_PEEK, v); check("R5 peek twice", v, stat(8'hA1));
        rd(A_POP, v);  check("R5 pop 1", v, stat(8'hA1));
        rd(A_POP, v);  check("R5 pop 2", v, stat(8'hB2));
        rd(A_POP, v);  check("R5 pop 3", v, stat(8'hC3));
        rd(A_POP, v);  check("R5 pop empty", v & 32'hFFFF_0000, 32'h0140_0000);
        rd(A_RAW, v);  check("R9 raw rx clear", v, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        for (int i = 0; i < 18; i++) push(8'h10 + 8'(i));
        for (int i = 0; i < 16; i++) begin
            rd(A_POP, v);
            check("R4 fifo order", v, stat(8'h10 + 8'(i)));
        end
        rd(A_PEEK, v); check("R4 extra dropped", v & 32'hFFFF_0000, 32'h0140_0000);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        push(8'h55);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = A_POP;
        rx_valid = 1'b1; rx_data = 8'h66;
        @(negedge clk);
        v = bus_rdata;
        bus_en = 1'b0; rx_valid = 1'b0;
        check("R6 pop result", v, stat(8'h55));
        rd(A_POP, v);  check("R6 pushed byte kept", v, stat(8'h66));
        rd(A_PEEK, v); check("R6 now empty", v & 32'hFFFF_0000, 32'h0140_0000);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        check("R7 idle strobe", {31'h0, tx_valid}, 32'h0);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_DOUT; bus_wdata = 32'h1234_56AB;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        check("R7 strobe high", {31'h0, tx_valid}, 32'h1);
        check("R7 tx byte", {24'h0, tx_data}, 32'hAB);
        @(negedge clk);
        check("R7 strobe one clock", {31'h0, tx_valid}, 32'h0);
        rd(A_RAW, v);  check("R7 raw bits", v, 32'h3);
        rd(A_DOUT, v); check("R7 dout readback", v, 32'h1234_56AB);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        wr(A_ACK, 32'h3);
        rd(A_RAW, v); check("R8 first ack keeps bit0", v, 32'h1);
        rd(A_ACK, v); check("R8 ack readback", v, 32'h2);
        wr(A_ACK, 32'h1);
        rd(A_RAW, v); check("R8 second ack clears", v, 32'h0);
        rd(A_ACK, v); check("R8 ack readback 2", v, 32'h1);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(A_MASK, 32'h8);
        check("R10 irq idle", {31'h0, irq}, 32'h0);
        push(8'h77);
        check("R10 irq rx", {31'h0, irq}, 32'h1);
        rd(A_MASKED, v); check("R10 masked", v, 32'h8);
        rd(A_POP, v);    check("R10 pop byte", v, stat(8'h77));
        check("R10 irq drops", {31'h0, irq}, 32'h0);
        wr(A_MASK, 32'h2);
        wr(A_DOUT, 32'h5A);
        check("R10 irq tx", {31'h0, irq}, 32'h1);
        rd(A_MASKED, v); check("R10 masked tx", v, 32'h2);
        wr(A_ACK, 32'h2);
        check("R10 irq acked", {31'h0, irq}, 32'h0);
        wr(A_ACK, 32'h1);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(A_RAW, 32'hFFFF_FFFF);
        rd(A_RAW, v);    check("R9 raw write ignored", v, 32'h0);
        wr(A_MASK, 32'hFFFF_FFFF);
        wr(A_MASKED, 32'hFFFF_FFFF);
        rd(A_MASKED, v); check("R9 masked write ignored", v, 32'h0);
        check("R9 irq still low", {31'h0, irq}, 32'h0);
        wr(A_GEN, 32'hCAFE_F00D);
        rd(A_GEN, v);    check("R11 store", v, 32'hCAFE_F00D);
        wr(A_HOLE, 32'h1111_2222);
        rd(A_HOLE, v);   check("R11 0x3C zero", v, 32'h0);
        wr(A_FAR, 32'h3333_4444);
        rd(A_FAR, v);    check("R11 0x40 zero", v, 32'h0);
        rd(A_GEN, v);    check("R11 store intact", v, 32'hCAFE_F00D);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_gate();
        t_peek_pop();
        t_overflow();
        t_same_cycle();
        t_tx();
        t_ack();
        t_irq();
        t_map();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule